// File: doc/BRIEF.md
# Bufferless Spike Switch Box

The switch box sits at one node of a grid of compute tiles and carries one-bit spike events. Spikes arrive from the switches to the north, south, east and west, and from the local tile. Each group has `CH_PER_SIDE` single-bit channels. The same five groups leave the switch on the output side. There is no separate connection box: the tile group is simply the fifth side of the same crossbar.

Each outgoing channel owns an enable mask with one bit per incoming channel. The output is high in any cycle where at least one enabled input is high. Setting the same input in several masks copies a spike onto several outputs (branching). Setting several inputs in one mask funnels them onto one output (merging).

Nothing is stored on the spike path. There are no buffers, no pipeline stage and no flow control. Spikes that coincide on one output therefore collapse into a single spike, and the extra ones are lost. The spike channels carry no valid/ready pair and apply no back-pressure: a spike that cannot leave is dropped, never held.

The masks are loaded through a plain register-write port while `run` is low. They are frozen while `run` is high.

Top module: `spike_switch_box`

## Requirements
- R1: After reset every mask is zero, so with `run` high no input pattern makes any output fire.
- R2: With `run` low, a cycle with `cfg_we` high and `cfg_sel` below 5*`CH_PER_SIDE` loads `cfg_mask` into the mask of output `cfg_sel` at that clock edge. A later write to the same output replaces the earlier mask.
- R3: A write attempted while `run` is high changes no mask.
- R4: A write whose `cfg_sel` is 5*`CH_PER_SIDE` or more changes no mask.
- R5: While `run` is low every output is 0, whatever the inputs.
- R6: While `run` is high, `spk_out[o]` equals the OR of `spk_in & mask[o]` in the same cycle. Nothing is held, so an output falls as soon as its inputs fall.
- R7: An input enabled in several masks appears on all of those outputs in the same cycle.
- R8: Coincident spikes on several inputs of one mask produce exactly one high output bit for that cycle, not two events.
- R9: An output whose mask is all zero never fires.
- R10: Channel numbering: the side order is north=0, south=1, east=2, west=3, tile=4. Side s, channel c is bit s*`CH_PER_SIDE`+c of `spk_in`, `spk_out` and `cfg_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset, clears all masks |
| run | input | 1 | High: forward spikes and freeze masks. Low: outputs idle and writes allowed |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | $clog2(5*CH_PER_SIDE) | Index of the output whose mask is written |
| cfg_mask | input | 5*CH_PER_SIDE | Mask value, one bit per input channel |
| spk_in | input | 5*CH_PER_SIDE | Incoming spike channels, all five sides |
| spk_out | output | 5*CH_PER_SIDE | Outgoing spike channels, all five sides |

## Verification
A wrong mask bit shows at the ports as a spike copied onto an output that should stay silent, or as a missing copy. It appears in the same cycle as the first input pulse that exercises that bit, because the spike path has no register. A mask that changes while running, or a write that lands on the wrong row, shows the same way on the next pulse through the affected output. The bench therefore loads a known mapping, sweeps input patterns that touch every loaded row and several empty ones, and then repeats the full pattern after each rejected write.

// File: rtl/spike_switch_pkg.sv
package spike_switch_pkg;
  localparam int NUM_SIDES = 5;

  typedef enum logic [2:0] {
    SIDE_N = 3'd0,
    SIDE_S = 3'd1,
    SIDE_E = 3'd2,
    SIDE_W = 3'd3,
    SIDE_T = 3'd4
  } side_e;

  // Flat channel index for side s, channel c (R10)
  function automatic int chan_idx(side_e s, int c, int per_side);
    return int'(s) * per_side + c;
  endfunction
endpackage

// File: rtl/spike_cfg_bank.sv
module spike_cfg_bank #(
  parameter int NCH  = 20,
  parameter int SELW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                cfg_we,
  input  logic [SELW-1:0]     cfg_sel,
  input  logic [NCH-1:0]      cfg_mask,
  output logic [NCH*NCH-1:0]  mask_flat
);
  for (genvar o = 0; o < NCH; o++) begin : g_row
    logic [NCH-1:0] row_q;
    logic           row_wr;

    assign row_wr = cfg_we && !run && (cfg_sel == SELW'(o));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (row_wr) row_q <= cfg_mask;
    end

    assign mask_flat[o*NCH +: NCH] = row_q;
  end

  // R3
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mask_flat));

  // R4
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (int'(cfg_sel) >= NCH)) |=> $stable(mask_flat));
endmodule

// File: rtl/spike_merge_lane.sv
module spike_merge_lane #(
  parameter int NCH = 20
) (
  input  logic           run,
  input  logic [NCH-1:0] spk_in,
  input  logic [NCH-1:0] mask,
  output logic           spk_o
);
  logic [NCH-1:0] hits;

  always_comb begin
    hits  = spk_in & mask;
    spk_o = run && (|hits);
  end
endmodule

// File: rtl/spike_switch_box.sv
module spike_switch_box #(
  parameter int  CH_PER_SIDE = 4,
  localparam int NCH  = spike_switch_pkg::NUM_SIDES * CH_PER_SIDE,
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [NCH-1:0]  cfg_mask,
  input  logic [NCH-1:0]  spk_in,
  output logic [NCH-1:0]  spk_out
);
  logic [NCH*NCH-1:0] mask_flat;

  spike_cfg_bank #(.NCH(NCH), .SELW(SELW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_mask (cfg_mask),
    .mask_flat(mask_flat)
  );

  for (genvar o = 0; o < NCH; o++) begin : g_lane
    spike_merge_lane #(.NCH(NCH)) u_lane (
      .run   (run),
      .spk_in(spk_in),
      .mask  (mask_flat[o*NCH +: NCH]),
      .spk_o (spk_out[o])
    );

    // R9
    unconfigured_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_flat[o*NCH +: NCH] == '0) |-> !spk_out[o]);
  end

  // R5
  idle_when_config_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (spk_out == '0));

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_in == '0) |-> (spk_out == '0));
endmodule

// File: tb/spike_switch_box_test.sv
`timescale 1ns/1ps
module spike_switch_box_test;
  import spike_switch_pkg::*;

  localparam int CPS = 4;
  localparam int N   = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_sel = '0;
  logic [N-1:0]  cfg_mask = '0;
  logic [N-1:0]  spk_in = '0;
  logic [N-1:0]  spk_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spike_switch_box #(.CH_PER_SIDE(CPS)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_mask(cfg_mask), .spk_in(spk_in), .spk_out(spk_out)
  );

  // {stimulus, expected} for the mapping loaded below (R6 R7 R8 R9)
  localparam logic [2*N-1:0] VEC [10] = '{
    {20'h00000, 20'h00000},
    {20'h10000, 20'h00101},
    {20'h01000, 20'h00100},
    {20'h11000, 20'h00101},
    {20'h00001, 20'h20000},
    {20'h00111, 20'h20000},
    {20'h00002, 20'h00020},
    {20'hFFFFF, 20'h20121},
    {20'h8000C, 20'h00000},
    {20'h10002, 20'h00121}
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", req, act, exp);
    end
  endtask

  task automatic write_mask(input int sel, input logic [N-1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 5'(sel); cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0; cfg_mask = '0;
  endtask

  task automatic drive_check(input string req, input logic [N-1:0] stim, input logic [N-1:0] exp);
    @(negedge clk);
    spk_in = stim;
    #2;
    check(req, spk_out, exp);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: masks clear after reset
    run = 1'b1;
    drive_check("R1", 20'hFFFFF, 20'h00000);
    run = 1'b0;
    // R5: outputs idle while configuring
    drive_check("R5", 20'hFFFFF, 20'h00000);
    spk_in = '0;

    // R10: indices from side order N,S,E,W,T
    write_mask(chan_idx(SIDE_N, 0, CPS), N'(1) << chan_idx(SIDE_T, 0, CPS));
    write_mask(chan_idx(SIDE_E, 0, CPS),
               (N'(1) << chan_idx(SIDE_W, 0, CPS)) | (N'(1) << chan_idx(SIDE_T, 0, CPS)));
    write_mask(chan_idx(SIDE_T, 1, CPS),
               (N'(1) << chan_idx(SIDE_N, 0, CPS)) | (N'(1) << chan_idx(SIDE_S, 0, CPS)) |
               (N'(1) << chan_idx(SIDE_E, 0, CPS)));
    write_mask(chan_idx(SIDE_S, 1, CPS), N'(1) << chan_idx(SIDE_N, 1, CPS));

    drive_check("R5", 20'hFFFFF, 20'h00000);
    run = 1'b1;

    // R2 R6 R7 R8 R9 R10 table
    for (int i = 0; i < 10; i++)
      drive_check("R6/R7/R8/R9 R2 R10", VEC[i][2*N-1:N], VEC[i][N-1:0]);

    // R6: no storage, single-cycle pulse falls at once
    drive_check("R6", 20'h10000, 20'h00101);
    drive_check("R6", 20'h00000, 20'h00000);

    // R3: write while running is ignored
    write_mask(9, 20'hFFFFF);
    drive_check("R3", 20'hFFFFF, 20'h20121);

    // R4: out-of-range selectors ignored
    run = 1'b0;
    write_mask(25, 20'hFFFFF);
    write_mask(31, 20'hFFFFF);
    run = 1'b1;
    drive_check("R4", 20'hFFFFF, 20'h20121);

    // R2: overwrite, R9: output 0 now empty
    run = 1'b0;
    write_mask(0, 20'h00000);
    run = 1'b1;
    drive_check("R2", 20'h10000, 20'h00100);
    drive_check("R9", 20'hFFFFF, 20'h20120);

    spk_in = '0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule